// File: doc/BRIEF.md
# Coordinated Prefetcher Throttle Controller

This block steers the aggressiveness of two prefetchers that compete for the same memory bandwidth. One is a sequential stream prefetcher and the other is a pointer-chasing prefetcher. Single-cycle event pulses arrive from the cache: a prefetch issued by either engine, a demand hit on a line that one engine brought in and that is still marked as prefetched, a demand miss, and an L2 eviction. The block keeps saturating counters for these events. The sampling interval closes on a fixed number of evictions.

When an interval closes, the block works out each engine's accuracy (useful / issued) and coverage (useful / (useful + demand misses)). Each engine is then judged in turn as the deciding engine, with the other engine as its rival. The judgement combines three things: the deciding engine's accuracy band, its own coverage, and the rival's coverage. The result is one of three actions: step up, step down, or hold. Both engines' levels move in the same clock edge, and every event counter is halved at that edge so that older history decays.

The stream engine's setting is a level code from 0 to 4, which the block also presents as a prefetch distance and a degree. The pointer engine's setting is a maximum chase depth. All comparisons against the fractional thresholds use cross-multiplication, so the block needs no divider.

Top module: `pf_throttle_ctrl`

## Requirements
- R1: After reset the stream level is 3 (distance 32, degree 4) and the pointer depth is 4.
- R2: Stream level code L maps to distance 4·2^L. The degree is 1 for L of 0 or 1, 2 for L of 2, and 4 for L of 3 or 4.
- R3: The pointer depth stays within 1..4 and moves by at most one step per interval; a step up at depth 4 leaves it at 4.
- R4: An interval closes on every INTERVAL-th eviction pulse. Both levels change only at the clock edge that samples that pulse, and they are stable at every other edge.
- R5: A deciding engine whose accuracy is below 0.4 steps down.
- R6: A deciding engine whose accuracy is at least 0.4 and below 0.7 steps down if the rival's coverage is high (at least 0.2), and steps up otherwise.
- R7: A deciding engine whose accuracy is at least 0.7 holds when its own coverage is low and the rival's coverage is high; in every other high-accuracy case it steps up.
- R8: An engine that issued nothing holds its level and counts as low-coverage when it acts as the rival. Coverage is also low when useful + misses is zero.
- R9: Event counters saturate at 2^CNT_W−1 rather than wrapping. At interval close they are halved (rounding down), and a pulse in that same cycle is added after the halving.
- R10: The stream level saturates at 0 on a step down and at 4 on a step up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| str_issue | input | 1 | Stream engine issued a prefetch |
| str_useful | input | 1 | Demand hit on a line the stream engine prefetched |
| ptr_issue | input | 1 | Pointer engine issued a prefetch |
| ptr_useful | input | 1 | Demand hit on a line the pointer engine prefetched |
| dmd_miss | input | 1 | Demand miss in L2 |
| l2_evict | input | 1 | L2 eviction; paces the sampling interval |
| str_level | output | 3 | Stream aggressiveness level code 0..4 |
| str_distance | output | 7 | Stream prefetch distance in lines |
| str_degree | output | 3 | Stream prefetch degree |
| ptr_depth | output | 3 | Pointer engine maximum chase depth 1..4 |

## Verification
Directed intervals run from reset, one for each cell of the decision table. These cover low, medium and high accuracy against a rival with high and with low coverage. They include ratios that sit exactly on 0.4, 0.7 and 0.2, which tell strict comparisons apart from inclusive ones. Runs of consecutive low- and high-accuracy intervals drive both levels into their end stops. An over-full issue count separates saturation from wrap-around. A long arithmetic sweep without reset mixes all decision cells with carried, halved history, so it exposes any error in the decay or in the cross-wiring of rival coverage. At the last eviction edge the levels are compared before and after that edge, which pins the update to the closing pulse.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_UP   = 2'd1,
    ACT_DOWN = 2'd2
  } act_t;

  localparam int NUM_PF = 2;
  localparam int PF_STR = 0;
  localparam int PF_PTR = 1;
endpackage

// File: rtl/thr_sat_counter.sv
module thr_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         halve,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] base;
  logic [W-1:0] count_nxt;
  logic         cnt_en;

  always_comb begin
    base      = halve ? (count >> 1) : count;
    count_nxt = base;
    if (inc && (base != CMAX)) count_nxt = base + W'(1);
    cnt_en    = inc | halve;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= count_nxt;
  end

  // R9: a full counter does not wrap
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && inc && !halve) |=> (count == CMAX));

  // R9: interval close halves the count
  a_r9_halve: assert property (@(posedge clk) disable iff (!rst_n)
    (halve && !inc) |=> (count == ($past(count) >> 1)));
endmodule

// File: rtl/thr_judge.sv
module thr_judge
  import thr_pkg::*;
#(
  parameter int W          = 16,
  parameter int DEN        = 10,
  parameter int COV_NUM    = 2,
  parameter int ACC_LO_NUM = 4,
  parameter int ACC_HI_NUM = 7
) (
  input  logic [W-1:0] issued,
  input  logic [W-1:0] useful,
  input  logic [W-1:0] miss,
  input  logic         rival_cov_high,
  output logic         cov_high,
  output act_t         act
);
  localparam int XW = W + 1 + $clog2(DEN + 1);

  logic [XW-1:0] use_x;
  logic [XW-1:0] iss_x;
  logic [XW-1:0] demand_x;
  logic          acc_low;
  logic          acc_high;
  logic          idle;

  always_comb begin
    use_x    = XW'(useful) * XW'(DEN);
    iss_x    = XW'(issued);
    demand_x = XW'(useful) + XW'(miss);
    idle     = (issued == '0);
    cov_high = !idle && (demand_x != '0) && (use_x >= demand_x * XW'(COV_NUM));
    acc_low  = use_x <  iss_x * XW'(ACC_LO_NUM);
    acc_high = use_x >= iss_x * XW'(ACC_HI_NUM);

    if (idle)               act = ACT_HOLD;
    else if (acc_low)       act = ACT_DOWN;
    else if (!acc_high)     act = rival_cov_high ? ACT_DOWN : ACT_UP;
    else if (!cov_high && rival_cov_high) act = ACT_HOLD;
    else                    act = ACT_UP;
  end
endmodule

// File: rtl/thr_level_reg.sv
module thr_level_reg
  import thr_pkg::*;
#(
  parameter int LW      = 3,
  parameter int MIN_LVL = 0,
  parameter int MAX_LVL = 4,
  parameter int RST_LVL = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          apply,
  input  act_t          act,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] LO  = LW'(MIN_LVL);
  localparam logic [LW-1:0] HI  = LW'(MAX_LVL);
  localparam logic [LW-1:0] RST = LW'(RST_LVL);

  logic [LW-1:0] level_nxt;

  always_comb begin
    level_nxt = level;
    if (act == ACT_UP && level != HI)   level_nxt = level + LW'(1);
    if (act == ACT_DOWN && level != LO) level_nxt = level - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     level <= RST;
    else if (apply) level <= level_nxt;
  end

  // R4: no movement outside interval close
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(level));

  // R3: one step at most
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (level == $past(level)) || (level == $past(level) + LW'(1))
              || (level == $past(level) - LW'(1)));

  // R10: level stays between its end stops
  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= LO) && (level <= HI));
endmodule

// File: rtl/pf_throttle_ctrl.sv
module pf_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int INTERVAL = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       str_issue,
  input  logic       str_useful,
  input  logic       ptr_issue,
  input  logic       ptr_useful,
  input  logic       dmd_miss,
  input  logic       l2_evict,
  output logic [2:0] str_level,
  output logic [6:0] str_distance,
  output logic [2:0] str_degree,
  output logic [2:0] ptr_depth
);
  localparam int EW        = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam int BASE_DIST = 4;

  logic [EW-1:0]    ev_cnt;
  logic [EW-1:0]    ev_cnt_nxt;
  logic             tick;

  logic [NUM_PF-1:0] issue_v;
  logic [NUM_PF-1:0] useful_v;
  logic [CNT_W-1:0]  iss_cnt [NUM_PF];
  logic [CNT_W-1:0]  use_cnt [NUM_PF];
  logic [CNT_W-1:0]  miss_cnt;
  logic [NUM_PF-1:0] cov_high;
  act_t              act    [NUM_PF];

  assign issue_v  = {ptr_issue, str_issue};
  assign useful_v = {ptr_useful, str_useful};

  // interval pacing
  always_comb begin
    tick       = l2_evict && (ev_cnt == EW'(INTERVAL - 1));
    ev_cnt_nxt = tick ? '0 : ev_cnt + EW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ev_cnt <= '0;
    else if (l2_evict) ev_cnt <= ev_cnt_nxt;
  end

  // per-engine counters and judges
  for (genvar p = 0; p < NUM_PF; p++) begin : g_pf
    thr_sat_counter #(.W(CNT_W)) u_iss (
      .clk(clk), .rst_n(rst_n), .inc(issue_v[p]), .halve(tick), .count(iss_cnt[p])
    );
    thr_sat_counter #(.W(CNT_W)) u_use (
      .clk(clk), .rst_n(rst_n), .inc(useful_v[p]), .halve(tick), .count(use_cnt[p])
    );
    thr_judge #(.W(CNT_W)) u_judge (
      .issued(iss_cnt[p]), .useful(use_cnt[p]), .miss(miss_cnt),
      .rival_cov_high(cov_high[NUM_PF-1-p]),
      .cov_high(cov_high[p]), .act(act[p])
    );
  end

  thr_sat_counter #(.W(CNT_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc(dmd_miss), .halve(tick), .count(miss_cnt)
  );

  thr_level_reg #(.LW(3), .MIN_LVL(0), .MAX_LVL(4), .RST_LVL(3)) u_str_lvl (
    .clk(clk), .rst_n(rst_n), .apply(tick), .act(act[PF_STR]), .level(str_level)
  );
  thr_level_reg #(.LW(3), .MIN_LVL(1), .MAX_LVL(4), .RST_LVL(4)) u_ptr_lvl (
    .clk(clk), .rst_n(rst_n), .apply(tick), .act(act[PF_PTR]), .level(ptr_depth)
  );

  // stream level to distance / degree
  always_comb begin
    str_distance = 7'(BASE_DIST << str_level);
    if (str_level < 3'd2)       str_degree = 3'd1;
    else if (str_level == 3'd2) str_degree = 3'd2;
    else                        str_degree = 3'd4;
  end

  // R8: an engine with nothing issued never moves
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && iss_cnt[PF_STR] == '0) |=> $stable(str_level));
endmodule

// File: tb/pf_throttle_ctrl_test.sv
`timescale 1ns/1ps
module pf_throttle_ctrl_test;
  localparam int W    = 8;
  localparam int INTV = 16;
  localparam int CMAX = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic str_issue, str_useful, ptr_issue, ptr_useful, dmd_miss, l2_evict;
  logic [2:0] str_level, str_degree, ptr_depth;
  logic [6:0] str_distance;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model state
  int m_si, m_su, m_pi, m_pu, m_mi;
  int m_sl, m_pd;

  always #2.5 clk = ~clk;

  pf_throttle_ctrl #(.CNT_W(W), .INTERVAL(INTV)) uut (
    .clk(clk), .rst_n(rst_n),
    .str_issue(str_issue), .str_useful(str_useful),
    .ptr_issue(ptr_issue), .ptr_useful(ptr_useful),
    .dmd_miss(dmd_miss), .l2_evict(l2_evict),
    .str_level(str_level), .str_distance(str_distance),
    .str_degree(str_degree), .ptr_depth(ptr_depth)
  );

  task automatic chk(int act_v, int exp_v, string req, string what);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  task automatic check_all(string req);
    int deg;
    deg = (m_sl < 2) ? 1 : ((m_sl == 2) ? 2 : 4);
    chk(int'(str_level), m_sl, req, "str_level");
    chk(int'(str_distance), 4 * (2 ** m_sl), {req, " R2"}, "str_distance");
    chk(int'(str_degree), deg, {req, " R2"}, "str_degree");
    chk(int'(ptr_depth), m_pd, req, "ptr_depth");
  endtask

  function automatic bit cov_hi(int iss, int use_n, int mi);
    if (iss == 0 || (use_n + mi) == 0) return 1'b0;
    return (real'(use_n) / real'(use_n + mi)) >= 0.2;
  endfunction

  function automatic int decide(int iss, int use_n, int mi, bit rival_hi);
    real acc;
    if (iss == 0) return 0;
    acc = real'(use_n) / real'(iss);
    if (acc < 0.4) return -1;
    if (acc < 0.7) return rival_hi ? -1 : 1;
    if (!cov_hi(iss, use_n, mi) && rival_hi) return 0;
    return 1;
  endfunction

  function automatic int sat_inc(int v);
    return (v == CMAX) ? v : v + 1;
  endfunction

  function automatic int clamp(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {str_issue, str_useful, ptr_issue, ptr_useful, dmd_miss, l2_evict} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_si = 0; m_su = 0; m_pi = 0; m_pu = 0; m_mi = 0;
    m_sl = 3; m_pd = 4;
  endtask

  task automatic run_interval(int si, int su, int pi, int pu, int mi, string req);
    int n;
    int ds, dp;
    n = si;
    if (su > n) n = su;
    if (pi > n) n = pi;
    if (pu > n) n = pu;
    if (mi > n) n = mi;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      str_issue = (c < si); str_useful = (c < su);
      ptr_issue = (c < pi); ptr_useful = (c < pu);
      dmd_miss  = (c < mi);
      if (c < si) m_si = sat_inc(m_si);
      if (c < su) m_su = sat_inc(m_su);
      if (c < pi) m_pi = sat_inc(m_pi);
      if (c < pu) m_pu = sat_inc(m_pu);
      if (c < mi) m_mi = sat_inc(m_mi);
    end
    for (int e = 0; e < INTV; e++) begin
      @(negedge clk);
      {str_issue, str_useful, ptr_issue, ptr_useful, dmd_miss} = '0;
      if (e == INTV - 1) check_all("R4 before close");
      l2_evict = 1'b1;
    end
    @(negedge clk);
    l2_evict = 1'b0;
    ds = decide(m_si, m_su, m_mi, cov_hi(m_pi, m_pu, m_mi));
    dp = decide(m_pi, m_pu, m_mi, cov_hi(m_si, m_su, m_mi));
    m_sl = clamp(m_sl + ds, 0, 4);
    m_pd = clamp(m_pd + dp, 1, 4);
    m_si = m_si >> 1; m_su = m_su >> 1; m_pi = m_pi >> 1;
    m_pu = m_pu >> 1; m_mi = m_mi >> 1;
    check_all(req);
  endtask

  initial begin
    rst_n = 1'b0;
    {str_issue, str_useful, ptr_issue, ptr_useful, dmd_miss, l2_evict} = '0;
    do_reset();
    @(negedge clk);
    check_all("R1 reset");

    // R5: both engines low accuracy
    do_reset(); run_interval(10, 2, 10, 3, 0, "R5 low acc");
    // R6: medium accuracy, rival coverage high
    do_reset(); run_interval(10, 5, 10, 5, 0, "R6 med rival hi");
    // R6: medium (0.4 exact) with rival coverage low; R3 top stop
    do_reset(); run_interval(10, 5, 10, 4, 100, "R6 med rival lo R3");
    // R7: high accuracy, own cov low, rival cov high -> hold
    do_reset(); run_interval(10, 8, 100, 25, 100, "R7 hold");
    // R7: high accuracy, own cov high; R8 idle pointer
    do_reset(); run_interval(10, 9, 0, 0, 0, "R7 up R8 idle");
    // R7 boundary: acc exactly 0.7, cov exactly 0.2
    do_reset(); run_interval(10, 7, 0, 0, 28, "R7 boundary");
    // R8: nothing issued by either engine
    do_reset(); run_interval(0, 0, 0, 0, 12, "R8 both idle");
    // R10 / R3: repeated low accuracy reaches the bottom stops
    do_reset();
    for (int k = 0; k < 6; k++) run_interval(10, 1, 10, 1, 2, "R10 R3 bottom");
    // R10: repeated high accuracy reaches the top stop
    do_reset();
    for (int k = 0; k < 3; k++) run_interval(10, 10, 0, 0, 0, "R10 top");
    // R9: issue count beyond counter range saturates
    do_reset(); run_interval(300, 100, 0, 0, 0, "R9 saturate");
    // sweep with carried, halved history: R5 R6 R7 R8 R9
    do_reset();
    for (int k = 0; k < 80; k++) begin
      int si, su, pi, pu, mi;
      si = (k * 7) % 13;
      su = (k * 5) % (si + 1);
      pi = (k * 11) % 9;
      pu = (k * 3) % (pi + 1);
      mi = (k * 13) % 20;
      run_interval(si, su, pi, pu, mi, "sweep R5 R6 R7 R9");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule